// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block sits between an interrupt source controller and one processor. It holds at most one pending interrupt, made of a source number and a priority. It also holds the processor's current priority and an inter-processor interrupt (IPI) request priority. It drives a single interrupt line to the processor. The source controller offers interrupts one at a time. The block either keeps an offer or sends it back as a reject request. A kept offer may push out a less favoured pending interrupt, and that interrupt is rejected in turn. Priorities compare numerically, and a lower value is more favoured. The value 0xff means the least favoured priority, or nothing at all.

The processor side is a one-operation register port with four operations: set the current priority, write the IPI priority, accept the pending interrupt, and end-of-interrupt (EOI). Accept and EOI use one 32-bit word. Bits 31:24 hold a priority and bits 23:0 hold a source number. Source number 0 means nothing is pending, and source number 2 is reserved for the IPI. Requests to the source controller leave on one registered channel that carries one pulse per cycle. The channel has three kinds: reject, EOI and resend-all.

A four-state machine sequences the work. The states are IDLE, LATCH, IPI_CHECK and RESEND. IDLE takes one operation or offer. IDLE moves to LATCH when a pending interrupt must first be rejected before a new one is stored. IDLE moves to IPI_CHECK after an IPI write, an EOI, or a priority write that is not more favoured. IPI_CHECK moves to LATCH when the IPI displaces a pending source. IPI_CHECK moves to RESEND, or back to IDLE, when no displacement is needed. LATCH moves to RESEND or to IDLE. RESEND always returns to IDLE. Both the processor and the source controller see the ready signals high only in IDLE.

Top module: `intr_present_unit`

## Requirements
- R1: After reset, irq_out is low and both ready outputs are high. An accept (cpu_op code 2) returns 0x00000000, because the current priority and the source number reset to 0. The pending priority and the IPI priority both reset to 0xff.
- R2: An offer with priority P is answered, one cycle after its handshake, by a reject request (req_kind code 1) that carries the offered source number, and nothing else changes. This happens when P is not below the current priority, or when a pending interrupt has a priority at or below P.
- R3: An offer that is not rejected, arriving when nothing is pending, is stored at once. irq_out is high one cycle after the handshake. irq_out is high exactly while a nonzero source number is pending.
- R4: An offer that is not rejected, arriving while another source is pending, first issues a reject request for the old source. The new source and priority are stored one cycle later.
- R5: Accept (cpu_op code 2) returns {current priority, pending source} on cpu_rdata and lowers irq_out. It then loads the current priority from the pending priority, clears the source field, and sets the pending priority to 0xff.
- R6: EOI (cpu_op code 3) copies bits 31:24 of cpu_wdata into the current priority and issues an EOI request (req_kind code 2) carrying bits 23:0. It then performs a resend, which ends with a resend-all request (req_kind code 3).
- R7: A current-priority write (cpu_op code 0, value in bits 31:24) that is more favoured than before drops a pending interrupt if the new value is at or below that interrupt's priority. Dropping clears the source, sets the pending priority to 0xff, lowers irq_out and issues a reject request for that source.
- R8: A more favoured current-priority write that does not meet the drop condition only updates the current priority. It issues no request and leaves irq_out and the pending interrupt as they were.
- R9: A current-priority write that is equal or less favoured performs a resend. The resend first presents the IPI if the IPI priority is below the current priority, and then issues a resend-all request.
- R10: An IPI write (cpu_op code 1, priority in cpu_wdata bits 7:0) with a value below the current priority presents the IPI. Presenting rejects any pending source, stores source number 2 with the IPI priority, and raises irq_out.
- R11: An IPI write is not presented when a pending interrupt has a priority at or below the IPI value. In that case no request is issued and the pending interrupt stays.
- R12: A processor operation has precedence over an offer. offer_ready is low whenever cpu_op_valid is high, and an offer that is not handshaken has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_ready | output | 1 | Offer taken this cycle (IDLE and no processor operation) |
| cpu_op_valid | input | 1 | Processor operation request |
| cpu_op | input | 2 | 0 set priority, 1 IPI write, 2 accept, 3 EOI |
| cpu_wdata | input | 32 | Operation data |
| cpu_ready | output | 1 | Operation taken this cycle (IDLE) |
| cpu_rdata | output | 32 | Word captured by the last accept |
| irq_out | output | 1 | Interrupt line to the processor |
| req_valid | output | 1 | One-cycle request pulse to the source controller |
| req_kind | output | 2 | 1 reject, 2 EOI, 3 resend-all |
| req_num | output | 24 | Source number of the request |

## Verification
The hardest situation to reach is an IPI that appears inside a resend after an EOI. That needs an IPI priority stored earlier while it was blocked, together with an EOI that relaxes the current priority. The directed sequence builds this in stages. An IPI is first presented and then displaced by a better offer. The IPI is rewritten while blocked, and the offer is accepted. The next EOI must then produce the EOI request, the IPI, and the resend request in that order. The same run leaves an IPI pending for the drop test that follows.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    typedef enum logic [1:0] {
        OP_SET_PRIO = 2'd0,
        OP_SET_IPI  = 2'd1,
        OP_ACCEPT   = 2'd2,
        OP_EOI      = 2'd3
    } cpu_op_e;

    typedef enum logic [1:0] {
        RQ_NONE   = 2'd0,
        RQ_REJECT = 2'd1,
        RQ_EOI    = 2'd2,
        RQ_RESEND = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATCH,
        ST_IPI_CHECK,
        ST_RESEND
    } state_e;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_OFFER_REJ,
        ACT_OFFER_TAKE,
        ACT_OFFER_DISP,
        ACT_PRIO_DROP,
        ACT_PRIO_SET,
        ACT_IPI_WR,
        ACT_ACCEPT,
        ACT_EOI,
        ACT_IPI_TAKE,
        ACT_IPI_DISP,
        ACT_LATCH,
        ACT_RESEND
    } action_e;

endpackage

// File: rtl/ipu_offer_eval.sv
module ipu_offer_eval #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              pend_live,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              take,
    output logic              displace
);
    logic beats_cpu;
    logic blocked;

    always_comb begin
        beats_cpu = cand_prio < cur_prio;
        blocked   = pend_live && (pend_prio <= cand_prio);
        take      = beats_cpu && !blocked;
        displace  = take && pend_live;
    end
endmodule

// File: rtl/ipu_ctrl.sv
module ipu_ctrl
    import ipu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpu_op_valid,
    input  cpu_op_e cpu_op,
    input  logic    offer_valid,
    input  logic    offer_take,
    input  logic    offer_disp,
    input  logic    ipi_take,
    input  logic    ipi_disp,
    input  logic    prio_more_fav,
    input  logic    prio_drop,
    output action_e action,
    output logic    cpu_ready,
    output logic    offer_ready
);
    state_e state_q, state_d;
    logic   resend_q, resend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            resend_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            resend_q <= resend_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        resend_d    = resend_q;
        action      = ACT_NONE;
        cpu_ready   = (state_q == ST_IDLE);
        offer_ready = (state_q == ST_IDLE) && !cpu_op_valid;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_op_valid) begin
                    unique case (cpu_op)
                        OP_SET_PRIO: begin
                            if (prio_more_fav) begin
                                action = prio_drop ? ACT_PRIO_DROP : ACT_PRIO_SET;
                            end else begin
                                action   = ACT_PRIO_SET;
                                state_d  = ST_IPI_CHECK;
                                resend_d = 1'b1;
                            end
                        end
                        OP_SET_IPI: begin
                            action   = ACT_IPI_WR;
                            state_d  = ST_IPI_CHECK;
                            resend_d = 1'b0;
                        end
                        OP_ACCEPT: action = ACT_ACCEPT;
                        OP_EOI: begin
                            action   = ACT_EOI;
                            state_d  = ST_IPI_CHECK;
                            resend_d = 1'b1;
                        end
                    endcase
                end else if (offer_valid) begin
                    if (!offer_take) begin
                        action = ACT_OFFER_REJ;
                    end else if (offer_disp) begin
                        action   = ACT_OFFER_DISP;
                        state_d  = ST_LATCH;
                        resend_d = 1'b0;
                    end else begin
                        action = ACT_OFFER_TAKE;
                    end
                end
            end
            ST_IPI_CHECK: begin
                if (ipi_take && ipi_disp) begin
                    action  = ACT_IPI_DISP;
                    state_d = ST_LATCH;
                end else begin
                    action  = ipi_take ? ACT_IPI_TAKE : ACT_NONE;
                    state_d = resend_q ? ST_RESEND : ST_IDLE;
                end
            end
            ST_LATCH: begin
                action  = ACT_LATCH;
                state_d = resend_q ? ST_RESEND : ST_IDLE;
            end
            ST_RESEND: begin
                action  = ACT_RESEND;
                state_d = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit
    import ipu_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      offer_valid,
    input  logic [SRC_W-1:0]          offer_src,
    input  logic [PRIO_W-1:0]         offer_prio,
    output logic                      offer_ready,
    input  logic                      cpu_op_valid,
    input  logic [1:0]                cpu_op,
    input  logic [SRC_W+PRIO_W-1:0]   cpu_wdata,
    output logic                      cpu_ready,
    output logic [SRC_W+PRIO_W-1:0]   cpu_rdata,
    output logic                      irq_out,
    output logic                      req_valid,
    output logic [1:0]                req_kind,
    output logic [SRC_W-1:0]          req_num
);
    localparam int REG_W = SRC_W + PRIO_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};
    localparam logic [SRC_W-1:0]  SRC_NONE  = '0;
    localparam logic [SRC_W-1:0]  SRC_IPI   = SRC_W'(IPI_SRC);

    logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q, hold_prio_q;
    logic [SRC_W-1:0]  src_q, hold_src_q, req_num_q;
    logic [REG_W-1:0]  rdata_q;
    logic              irq_q, req_valid_q;
    req_kind_e         req_kind_q;

    logic [PRIO_W-1:0] wr_prio;
    logic [SRC_W-1:0]  wr_src;
    logic              pend_live;
    logic              offer_take, offer_disp, ipi_take, ipi_disp;
    logic              prio_more_fav, prio_drop;
    action_e           action;

    always_comb begin
        wr_prio       = cpu_wdata[REG_W-1 -: PRIO_W];
        wr_src        = cpu_wdata[SRC_W-1:0];
        pend_live     = (src_q != SRC_NONE);
        prio_more_fav = wr_prio < cppr_q;
        prio_drop     = pend_live && (wr_prio <= pend_q);
    end

    ipu_offer_eval #(.PRIO_W(PRIO_W)) u_offer_eval (
        .cur_prio  (cppr_q),
        .pend_prio (pend_q),
        .pend_live (pend_live),
        .cand_prio (offer_prio),
        .take      (offer_take),
        .displace  (offer_disp)
    );

    ipu_offer_eval #(.PRIO_W(PRIO_W)) u_ipi_eval (
        .cur_prio  (cppr_q),
        .pend_prio (pend_q),
        .pend_live (pend_live),
        .cand_prio (mfrr_q),
        .take      (ipi_take),
        .displace  (ipi_disp)
    );

    ipu_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_op_valid  (cpu_op_valid),
        .cpu_op        (cpu_op_e'(cpu_op)),
        .offer_valid   (offer_valid),
        .offer_take    (offer_take),
        .offer_disp    (offer_disp),
        .ipi_take      (ipi_take),
        .ipi_disp      (ipi_disp),
        .prio_more_fav (prio_more_fav),
        .prio_drop     (prio_drop),
        .action        (action),
        .cpu_ready     (cpu_ready),
        .offer_ready   (offer_ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cppr_q      <= '0;
            src_q       <= SRC_NONE;
            pend_q      <= PRIO_NONE;
            mfrr_q      <= PRIO_NONE;
            hold_src_q  <= SRC_NONE;
            hold_prio_q <= PRIO_NONE;
            irq_q       <= 1'b0;
            rdata_q     <= '0;
            req_valid_q <= 1'b0;
            req_kind_q  <= RQ_NONE;
            req_num_q   <= '0;
        end else begin
            req_valid_q <= 1'b0;
            req_kind_q  <= RQ_NONE;
            req_num_q   <= '0;
            unique case (action)
                ACT_NONE: ;
                ACT_OFFER_REJ: begin
                    req_valid_q <= 1'b1;
                    req_kind_q  <= RQ_REJECT;
                    req_num_q   <= offer_src;
                end
                ACT_OFFER_TAKE: begin
                    src_q  <= offer_src;
                    pend_q <= offer_prio;
                    irq_q  <= 1'b1;
                end
                ACT_OFFER_DISP: begin
                    req_valid_q <= 1'b1;
                    req_kind_q  <= RQ_REJECT;
                    req_num_q   <= src_q;
                    hold_src_q  <= offer_src;
                    hold_prio_q <= offer_prio;
                end
                ACT_PRIO_DROP: begin
                    cppr_q      <= wr_prio;
                    req_valid_q <= 1'b1;
                    req_kind_q  <= RQ_REJECT;
                    req_num_q   <= src_q;
                    src_q       <= SRC_NONE;
                    pend_q      <= PRIO_NONE;
                    irq_q       <= 1'b0;
                end
                ACT_PRIO_SET: cppr_q <= wr_prio;
                ACT_IPI_WR:   mfrr_q <= cpu_wdata[PRIO_W-1:0];
                ACT_ACCEPT: begin
                    rdata_q <= {cppr_q, src_q};
                    irq_q   <= 1'b0;
                    cppr_q  <= pend_q;
                    src_q   <= SRC_NONE;
                    pend_q  <= PRIO_NONE;
                end
                ACT_EOI: begin
                    cppr_q      <= wr_prio;
                    req_valid_q <= 1'b1;
                    req_kind_q  <= RQ_EOI;
                    req_num_q   <= wr_src;
                end
                ACT_IPI_TAKE: begin
                    src_q  <= SRC_IPI;
                    pend_q <= mfrr_q;
                    irq_q  <= 1'b1;
                end
                ACT_IPI_DISP: begin
                    req_valid_q <= 1'b1;
                    req_kind_q  <= RQ_REJECT;
                    req_num_q   <= src_q;
                    hold_src_q  <= SRC_IPI;
                    hold_prio_q <= mfrr_q;
                end
                ACT_LATCH: begin
                    src_q  <= hold_src_q;
                    pend_q <= hold_prio_q;
                    irq_q  <= 1'b1;
                end
                ACT_RESEND: begin
                    req_valid_q <= 1'b1;
                    req_kind_q  <= RQ_RESEND;
                end
                default: ;
            endcase
        end
    end

    assign irq_out   = irq_q;
    assign cpu_rdata = rdata_q;
    assign req_valid = req_valid_q;
    assign req_kind  = req_kind_q;
    assign req_num   = req_num_q;
endmodule

// File: rtl/ipu_checks.sv
module ipu_checks
    import ipu_pkg::*;
#(
    parameter int SRC_W  = 24,
    parameter int PRIO_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    offer_valid,
    input logic                    offer_ready,
    input logic [SRC_W-1:0]        offer_src,
    input logic [PRIO_W-1:0]       offer_prio,
    input logic                    cpu_op_valid,
    input logic                    cpu_ready,
    input logic [1:0]              cpu_op,
    input logic [SRC_W+PRIO_W-1:0] cpu_wdata,
    input logic                    irq_out,
    input logic                    req_valid,
    input logic [1:0]              req_kind,
    input logic [SRC_W-1:0]        req_num,
    input logic [PRIO_W-1:0]       cppr_q,
    input logic [PRIO_W-1:0]       pend_q,
    input logic [SRC_W-1:0]        src_q
);
    p_irq_tracks_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (src_q != '0));

    p_empty_prio_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == '0) |-> (pend_q == {PRIO_W{1'b1}}));

    p_offer_bounce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && offer_ready && (offer_prio >= cppr_q))
        |=> (req_valid && req_kind == 2'd1 && req_num == $past(offer_src)));

    p_accept_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_op_valid && cpu_ready && cpu_op == 2'd2) |=> (!irq_out && src_q == '0));

    p_eoi_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_op_valid && cpu_ready && cpu_op == 2'd3)
        |=> (req_valid && req_kind == 2'd2 && req_num == $past(cpu_wdata[SRC_W-1:0])));

    p_cpu_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_op_valid |-> !offer_ready);
endmodule

bind intr_present_unit ipu_checks #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .offer_valid  (offer_valid),
    .offer_ready  (offer_ready),
    .offer_src    (offer_src),
    .offer_prio   (offer_prio),
    .cpu_op_valid (cpu_op_valid),
    .cpu_ready    (cpu_ready),
    .cpu_op       (cpu_op),
    .cpu_wdata    (cpu_wdata),
    .irq_out      (irq_out),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_num      (req_num),
    .cppr_q       (cppr_q),
    .pend_q       (pend_q),
    .src_q        (src_q)
);

// File: tb/intr_present_unit_tb.sv
`timescale 1ns/1ps
module intr_present_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        offer_ready;
    logic        cpu_op_valid = 1'b0;
    logic [1:0]  cpu_op = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        irq_out;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [23:0] req_num;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] log_q [0:63];
    int log_n = 0;

    always #2.5 clk = ~clk;

    intr_present_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .offer_ready(offer_ready),
        .cpu_op_valid(cpu_op_valid), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .irq_out(irq_out),
        .req_valid(req_valid), .req_kind(req_kind), .req_num(req_num)
    );

    always @(negedge clk) begin
        if (req_valid && log_n < 64) begin
            log_q[log_n] = {6'd0, req_kind, req_num};
            log_n++;
        end
    end

    function automatic logic [31:0] rq(input logic [1:0] k, input logic [23:0] n);
        return {6'd0, k, n};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        log_n = 0;
    endtask

    task automatic do_op(input logic [1:0] op, input logic [31:0] wd);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_op_valid = 1'b1; cpu_op = op; cpu_wdata = wd;
        @(negedge clk);
        cpu_op_valid = 1'b0;
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_offer(input logic [23:0] s, input logic [7:0] p);
        @(negedge clk);
        while (!offer_ready) @(negedge clk);
        offer_valid = 1'b1; offer_src = s; offer_prio = p;
        @(negedge clk);
        offer_valid = 1'b0;
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
        chk("R1 ready after reset", {30'd0, cpu_ready, offer_ready}, 32'd3);
        clear_log();
        do_offer(24'h10, 8'h05);
        chk("R2 reject at reset priority count", log_n, 1);
        chk("R2 reject at reset priority", log_q[0], rq(2'd1, 24'h10));
        clear_log();
        do_op(2'd2, 32'd0);
        chk("R1 accept after reset", cpu_rdata, 32'h0000_0000);
        chk("R1 no request on accept", log_n, 0);
        do_op(2'd0, 32'hff00_0000);
        chk("R9 equal priority resend only", log_n, 1);
        chk("R9 resend kind", log_q[0], rq(2'd3, 24'h0));
        chk("R1 ipi reset none", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_offer();
        clear_log();
        do_offer(24'h10, 8'h05);
        chk("R3 take raises irq", {31'd0, irq_out}, 32'd1);
        chk("R3 take no request", log_n, 0);
        do_offer(24'h11, 8'h05);
        chk("R2 blocked by pending", log_n, 1);
        chk("R2 blocked reject", log_q[0], rq(2'd1, 24'h11));
        clear_log();
        do_offer(24'h12, 8'h03);
        chk("R4 displacement count", log_n, 1);
        chk("R4 displaced reject", log_q[0], rq(2'd1, 24'h10));
        chk("R4 irq still high", {31'd0, irq_out}, 32'd1);
        do_op(2'd2, 32'd0);
        chk("R4 new source latched", cpu_rdata, 32'hff00_0012);
        chk("R5 accept lowers irq", {31'd0, irq_out}, 32'd0);
        do_op(2'd2, 32'd0);
        chk("R5 priority loaded from pending", cpu_rdata, 32'h0300_0000);
    endtask

    task automatic t_eoi();
        clear_log();
        do_op(2'd3, 32'h0500_0012);
        chk("R6 eoi count", log_n, 2);
        chk("R6 eoi request", log_q[0], rq(2'd2, 24'h12));
        chk("R6 resend after eoi", log_q[1], rq(2'd3, 24'h0));
        do_op(2'd2, 32'd0);
        chk("R6 priority from eoi word", cpu_rdata, 32'h0500_0000);
    endtask

    task automatic t_ipi();
        clear_log();
        do_op(2'd1, 32'h0000_0040);
        chk("R10 ipi raises irq", {31'd0, irq_out}, 32'd1);
        chk("R10 ipi no request", log_n, 0);
        do_op(2'd2, 32'd0);
        chk("R10 ipi source number", cpu_rdata, 32'hff00_0002);
        do_op(2'd1, 32'h0000_0020);
        chk("R10 second ipi", {31'd0, irq_out}, 32'd1);
        clear_log();
        do_offer(24'h30, 8'h10);
        chk("R4 offer displaces ipi", log_n, 1);
        chk("R4 ipi rejected", log_q[0], rq(2'd1, 24'h2));
        clear_log();
        do_op(2'd1, 32'h0000_0018);
        chk("R11 blocked ipi no request", log_n, 0);
        do_op(2'd2, 32'd0);
        chk("R11 pending kept", cpu_rdata, 32'h4000_0030);
    endtask

    task automatic t_prio();
        clear_log();
        do_op(2'd3, 32'hff00_0030);
        chk("R9 resend sequence count", log_n, 2);
        chk("R6 eoi forwarded", log_q[0], rq(2'd2, 24'h30));
        chk("R9 resend last", log_q[1], rq(2'd3, 24'h0));
        chk("R9 resend presents ipi", {31'd0, irq_out}, 32'd1);
        clear_log();
        do_op(2'd0, 32'h1800_0000);
        chk("R7 drop count", log_n, 1);
        chk("R7 drop rejects ipi", log_q[0], rq(2'd1, 24'h2));
        chk("R7 drop lowers irq", {31'd0, irq_out}, 32'd0);
        clear_log();
        do_op(2'd0, 32'h0800_0000);
        chk("R8 nothing pending no request", log_n, 0);
        do_offer(24'h50, 8'h04);
        chk("R3 take under new priority", {31'd0, irq_out}, 32'd1);
        do_op(2'd0, 32'h0600_0000);
        chk("R8 no drop no request", log_n, 0);
        chk("R8 irq kept", {31'd0, irq_out}, 32'd1);
        do_op(2'd2, 32'd0);
        chk("R8 pending kept", cpu_rdata, 32'h0600_0050);
        clear_log();
        do_op(2'd0, 32'h0400_0000);
        chk("R9 equal write resend", log_n, 1);
        chk("R9 equal write kind", log_q[0], rq(2'd3, 24'h0));
        chk("R9 ipi not below", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_arb();
        clear_log();
        @(negedge clk);
        cpu_op_valid = 1'b1; cpu_op = 2'd2; cpu_wdata = '0;
        offer_valid = 1'b1; offer_src = 24'h60; offer_prio = 8'h01;
        #1;
        chk("R12 offer held off", {31'd0, offer_ready}, 32'd0);
        @(negedge clk);
        cpu_op_valid = 1'b0; offer_valid = 1'b0;
        @(negedge clk);
        chk("R12 cpu op served", cpu_rdata, 32'h0400_0000);
        chk("R12 offer no request", log_n, 0);
        do_op(2'd2, 32'd0);
        chk("R12 offer not stored", cpu_rdata, 32'hff00_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offer();
        t_eoi();
        t_ipi();
        t_prio();
        t_arb();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule